// File: doc/BRIEF.md
# Shadow Register Bank Stack with Error Traps

This block keeps a last-in, first-out stack of shadow register banks used to save a processor's context quickly on interrupt entry. When an interrupt that uses a bank is taken, the register contents are written into the next free bank. These contents are modelled as one opaque data word. A bank-restore instruction pops the most recently saved bank back out.

The block also detects two misuse cases and turns each into a trap. An overflow occurs when a save is requested while every bank is occupied and the overflow trap is enabled. An underflow occurs when a restore is requested while no bank is occupied. A trap runs a fixed sequence over a request/acknowledge memory port:

1. It reads the handler address from the vector table.
2. It pushes the status word to the memory stack.
3. It pushes the return address to the memory stack.
4. It issues a single-cycle redirect with the updated status word and stack pointer.

On overflow, the interrupt level of the offending request is copied into the status mask field. This blocks re-entry of that interrupt.

Top module: `regbank_trap_ctrl`

## Requirements
- R1: After reset `bank_cnt` is 0, and `busy`, `mem_req`, `redir_valid` and `restore_valid` are all 0.
- R2: A save request while `busy` is low and `bank_cnt` < NB (default 15) stores `save_data` into the next bank and raises `bank_cnt` by one. `bank_cnt` never exceeds NB.
- R3: A restore request while `busy` is low and `bank_cnt` > 0 lowers `bank_cnt` by one. In the following cycle `restore_valid` pulses high for one cycle, and `restore_data` carries the most recently saved word (LIFO order).
- R4: A save request with `bank_cnt` == NB and `ovf_trap_en` high starts an overflow trap. Its vector read address is `vec_base` + OVF_OFF (default 0x60).
- R5: A save request with `bank_cnt` == NB and `ovf_trap_en` low is absorbed. It causes no save, no change of `bank_cnt` and no trap.
- R6: A restore request with `bank_cnt` == 0 starts an underflow trap. Its vector read address is `vec_base` + UNF_OFF (default 0x64).
- R7: A trap performs three memory transfers in this order:
  - a read of the vector address;
  - a write of the captured status word to `sp_cur`-4;
  - a write of the return address to `sp_cur`-8.

  It then pulses `redir_valid` for one cycle, with `redir_pc` equal to the word read and `sp_new` equal to `sp_cur`-8.
- R8: The return address pushed is `next_pc` on overflow and `restore_pc` on underflow, each captured in the cycle the trap starts.
- R9: On overflow, `sr_new` equals the captured status word with bits 7:4 replaced by `irq_level`. On underflow, `sr_new` equals the captured status word unchanged.
- R10: `busy` is high from the cycle after a trap starts through the redirect cycle. Save and restore requests seen while `busy` is high are ignored, so `bank_cnt` stays unchanged and no `restore_valid` occurs.
- R11: When a save and a restore are requested in the same idle cycle, the save is acted on and the restore is ignored.
- R12: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_take | input | 1 | An interrupt that uses a bank is taken (save request) |
| irq_level | input | 4 | Priority level of that interrupt |
| save_data | input | DW | Register set to save |
| ovf_trap_en | input | 1 | Enables the overflow trap |
| restore_req | input | 1 | Bank-restore instruction executes |
| restore_pc | input | 32 | Address of the bank-restore instruction |
| next_pc | input | 32 | Address following the last executed instruction |
| sr_cur | input | 32 | Current status word |
| sp_cur | input | 32 | Current stack pointer |
| vec_base | input | 32 | Vector table base address |
| mem_ack | input | 1 | Memory transfer acknowledge |
| mem_rdata | input | 32 | Memory read data |
| restore_data | output | DW | Popped register set |
| restore_valid | output | 1 | `restore_data` valid pulse |
| bank_cnt | output | CW | Number of occupied banks |
| busy | output | 1 | Trap sequence in progress |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| redir_valid | output | 1 | Redirect to handler pulse |
| redir_pc | output | 32 | Handler address |
| sr_new | output | 32 | Status word to install at redirect |
| sp_new | output | 32 | Stack pointer to install at redirect |

## Verification
A save and a restore can arrive in the same idle cycle. The bench raises both at once with banks partly filled. It then expects the count to rise by one with no restore pulse, and expects the next restore to return the word just saved. A request can also arrive while a trap is running. The bench issues a restore and a save during an overflow trap and checks that the count is unchanged afterwards and that no restore pulse or extra memory transfer appears in the scoreboard.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int LVL_W = 4;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_VEC,
        TS_PSR,
        TS_PPC,
        TS_JMP
    } trap_st_e;

    typedef enum logic {
        TK_OVF,
        TK_UNF
    } trap_kind_e;

    typedef struct packed {
        trap_st_e         st;
        trap_kind_e       kind;
        logic [LVL_W-1:0] lvl;
        logic [31:0]      pc;
        logic [31:0]      sr;
        logic [31:0]      sp;
        logic [31:0]      vaddr;
        logic [31:0]      handler;
    } trap_reg_t;
endpackage

// File: rtl/bank_store.sv
module bank_store #(
    parameter int NB = 15,
    parameter int DW = 64,
    localparam int CW = $clog2(NB + 1),
    localparam int IW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] push_data,
    output logic [CW-1:0] cnt,
    output logic [DW-1:0] pop_data,
    output logic          pop_valid
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
        logic          valid;
    } store_reg_t;

    store_reg_t    st_d, st_q;
    logic [DW-1:0] banks [NB];
    logic [CW-1:0] top_idx;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        top_idx    = st_q.cnt - CW'(1);
        if (push) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end else if (pop) begin
            st_d.cnt   = top_idx;
            st_d.data  = banks[top_idx[IW-1:0]];
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            banks[st_q.cnt[IW-1:0]] <= push_data;
        end
    end

    assign cnt       = st_q.cnt;
    assign pop_data  = st_q.data;
    assign pop_valid = st_q.valid;
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import regbank_pkg::*;
#(
    parameter logic [31:0] OVF_OFF  = 32'h0000_0060,
    parameter logic [31:0] UNF_OFF  = 32'h0000_0064,
    parameter int          MASK_LSB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  trap_kind_e       kind,
    input  logic [LVL_W-1:0] lvl,
    input  logic [31:0]      ret_pc,
    input  logic [31:0]      sr_in,
    input  logic [31:0]      sp_in,
    input  logic [31:0]      vbase,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    output logic             redir_valid,
    output logic [31:0]      redir_pc,
    output logic [31:0]      sr_new,
    output logic [31:0]      sp_new
);
    trap_reg_t tr_d, tr_q;

    always_comb begin
        tr_d = tr_q;
        unique case (tr_q.st)
            TS_IDLE: begin
                if (start) begin
                    tr_d.st    = TS_VEC;
                    tr_d.kind  = kind;
                    tr_d.lvl   = lvl;
                    tr_d.pc    = ret_pc;
                    tr_d.sr    = sr_in;
                    tr_d.sp    = sp_in;
                    tr_d.vaddr = vbase + ((kind == TK_OVF) ? OVF_OFF : UNF_OFF);
                end
            end
            TS_VEC: begin
                if (mem_ack) begin
                    tr_d.handler = mem_rdata;
                    tr_d.st      = TS_PSR;
                end
            end
            TS_PSR:  if (mem_ack) tr_d.st = TS_PPC;
            TS_PPC:  if (mem_ack) tr_d.st = TS_JMP;
            TS_JMP:  tr_d.st = TS_IDLE;
            default: tr_d.st = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tr_q <= '0;
        end else begin
            tr_q <= tr_d;
        end
    end

    always_comb begin
        busy        = (tr_q.st != TS_IDLE);
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        redir_valid = (tr_q.st == TS_JMP);
        redir_pc    = tr_q.handler;
        sp_new      = tr_q.sp - 32'd8;
        sr_new      = tr_q.sr;
        if (tr_q.kind == TK_OVF) begin
            sr_new[MASK_LSB +: LVL_W] = tr_q.lvl;
        end
        unique case (tr_q.st)
            TS_VEC: begin
                mem_req  = 1'b1;
                mem_addr = tr_q.vaddr;
            end
            TS_PSR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tr_q.sp - 32'd4;
                mem_wdata = tr_q.sr;
            end
            TS_PPC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tr_q.sp - 32'd8;
                mem_wdata = tr_q.pc;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/regbank_trap_ctrl.sv
module regbank_trap_ctrl
    import regbank_pkg::*;
#(
    parameter int          NB       = 15,
    parameter int          DW       = 64,
    parameter logic [31:0] OVF_OFF  = 32'h0000_0060,
    parameter logic [31:0] UNF_OFF  = 32'h0000_0064,
    parameter int          MASK_LSB = 4,
    localparam int         CW       = $clog2(NB + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_take,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [DW-1:0]    save_data,
    input  logic             ovf_trap_en,
    input  logic             restore_req,
    input  logic [31:0]      restore_pc,
    input  logic [31:0]      next_pc,
    input  logic [31:0]      sr_cur,
    input  logic [31:0]      sp_cur,
    input  logic [31:0]      vec_base,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic [DW-1:0]    restore_data,
    output logic             restore_valid,
    output logic [CW-1:0]    bank_cnt,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    output logic             redir_valid,
    output logic [31:0]      redir_pc,
    output logic [31:0]      sr_new,
    output logic [31:0]      sp_new
);
    logic       save_go, rest_go, full, empty;
    logic       push, pop, ovf_hit, unf_hit, trap_go;
    trap_kind_e trap_kind;
    logic [31:0] trap_pc;

    always_comb begin
        full      = (bank_cnt == CW'(NB));
        empty     = (bank_cnt == '0);
        save_go   = irq_take && !busy;
        rest_go   = restore_req && !busy && !irq_take;
        push      = save_go && !full;
        pop       = rest_go && !empty;
        ovf_hit   = save_go && full && ovf_trap_en;
        unf_hit   = rest_go && empty;
        trap_go   = ovf_hit || unf_hit;
        trap_kind = ovf_hit ? TK_OVF : TK_UNF;
        trap_pc   = ovf_hit ? next_pc : restore_pc;
    end

    bank_store #(.NB(NB), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (save_data),
        .cnt       (bank_cnt),
        .pop_data  (restore_data),
        .pop_valid (restore_valid)
    );

    trap_seq #(.OVF_OFF(OVF_OFF), .UNF_OFF(UNF_OFF), .MASK_LSB(MASK_LSB)) u_trap (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (trap_go),
        .kind        (trap_kind),
        .lvl         (irq_level),
        .ret_pc      (trap_pc),
        .sr_in       (sr_cur),
        .sp_in       (sp_cur),
        .vbase       (vec_base),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .sr_new      (sr_new),
        .sp_new      (sp_new)
    );
endmodule

// File: rtl/regbank_trap_chk.sv
module regbank_trap_chk #(
    parameter int  NB = 15,
    localparam int CW = $clog2(NB + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_take,
    input logic          restore_req,
    input logic          restore_valid,
    input logic [CW-1:0] bank_cnt,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [31:0]   mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          redir_valid
);
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_cnt <= CW'(NB));

    // R3
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |-> bank_cnt == CW'($past(bank_cnt) - CW'(1)));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bank_cnt));

    // R10
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R7
    redir_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> busy && !mem_req);

    // R7
    redir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid && !busy);

    // R12
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R11
    save_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take && restore_req && !busy && bank_cnt < CW'(NB) |=> !restore_valid);
endmodule

bind regbank_trap_ctrl regbank_trap_chk #(.NB(NB)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_take      (irq_take),
    .restore_req   (restore_req),
    .restore_valid (restore_valid),
    .bank_cnt      (bank_cnt),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_ack       (mem_ack),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .redir_valid   (redir_valid)
);

// File: tb/sim_regbank_trap_ctrl.sv
module sim_regbank_trap_ctrl;
    localparam int NB = 15;
    localparam int DW = 64;
    localparam int CW = $clog2(NB + 1);
    localparam logic [31:0] OVF_OFF = 32'h0000_0060;
    localparam logic [31:0] UNF_OFF = 32'h0000_0064;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          irq_take = 1'b0;
    logic [3:0]    irq_level = '0;
    logic [DW-1:0] save_data = '0;
    logic          ovf_trap_en = 1'b0;
    logic          restore_req = 1'b0;
    logic [31:0]   restore_pc = 32'h0000_1200;
    logic [31:0]   next_pc = 32'h0000_3404;
    logic [31:0]   sr_cur = 32'h4000_0000;
    logic [31:0]   sp_cur = 32'h0800_0100;
    logic [31:0]   vec_base = 32'h0010_0000;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic [DW-1:0] restore_data;
    logic          restore_valid;
    logic [CW-1:0] bank_cnt;
    logic          busy, mem_req, mem_we, redir_valid;
    logic [31:0]   mem_addr, mem_wdata, redir_pc, sr_new, sp_new;

    regbank_trap_ctrl #(.NB(NB), .DW(DW), .OVF_OFF(OVF_OFF), .UNF_OFF(UNF_OFF)) u0 (.*);

    typedef struct {logic we; logic [31:0] addr; logic [31:0] data;} xfer_t;
    typedef struct {logic [31:0] pc; logic [31:0] sr; logic [31:0] sp;} redir_t;

    xfer_t         xq[$];
    redir_t        rq[$];
    logic [DW-1:0] dq[$];
    logic [DW-1:0] model[$];
    int checks = 0, errors = 0, ack_delay = 0, wait_c = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: memory responder, redirect and restore checks
    always @(negedge clk) begin
        if (restore_valid) begin
            if (dq.size() == 0) chk(1'b0, "R3 unexpected restore", restore_data, 0);
            else begin
                logic [DW-1:0] e;
                e = dq.pop_front();
                chk(restore_data == e, "R3 restore data", restore_data, e);
            end
        end
        if (redir_valid) begin
            if (rq.size() == 0) chk(1'b0, "R7 unexpected redirect", redir_pc, 0);
            else begin
                redir_t r;
                r = rq.pop_front();
                chk(redir_pc == r.pc, "R7 redirect pc", redir_pc, r.pc);
                chk(sr_new == r.sr, "R9 status word", sr_new, r.sr);
                chk(sp_new == r.sp, "R7 stack pointer", sp_new, r.sp);
            end
        end
        if (mem_ack) begin
            mem_ack = 1'b0;
            wait_c  = 0;
        end else if (mem_req) begin
            if (wait_c < ack_delay) wait_c++;
            else begin
                if (xq.size() == 0) chk(1'b0, "R7 unexpected transfer", mem_addr, 0);
                else begin
                    xfer_t x;
                    x = xq.pop_front();
                    chk(mem_we == x.we, "R7 transfer direction", mem_we, x.we);
                    chk(mem_addr == x.addr, "R7 transfer address", mem_addr, x.addr);
                    if (x.we) chk(mem_wdata == x.data, "R8 pushed word", mem_wdata, x.data);
                    else mem_rdata = x.data;
                end
                mem_ack = 1'b1;
                wait_c  = 0;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    task automatic pulse(input bit sv, input bit rs, input logic [DW-1:0] d, input logic [3:0] lvl);
        @(negedge clk);
        irq_take    = sv;
        restore_req = rs;
        save_data   = d;
        irq_level   = lvl;
        @(negedge clk);
        irq_take    = 1'b0;
        restore_req = 1'b0;
    endtask

    task automatic do_save(input logic [DW-1:0] d);
        if (model.size() < NB) model.push_back(d);
        pulse(1'b1, 1'b0, d, 4'h0);
    endtask

    task automatic do_restore();
        if (model.size() > 0) dq.push_back(model.pop_back());
        pulse(1'b0, 1'b1, '0, 4'h0);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_trap(input logic [31:0] vaddr, input logic [31:0] hnd,
                               input logic [31:0] pc, input logic [31:0] srx);
        xq.push_back('{1'b0, vaddr, hnd});
        xq.push_back('{1'b1, sp_cur - 32'd4, sr_cur});
        xq.push_back('{1'b1, sp_cur - 32'd8, pc});
        rq.push_back('{hnd, srx, sp_cur - 32'd8});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bank_cnt == 0, "R1 count", bank_cnt, 0);
        chk(!busy && !mem_req && !redir_valid && !restore_valid, "R1 flags",
            {busy, mem_req, redir_valid, restore_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 saves, R3 LIFO restores
        for (int i = 0; i < 3; i++) do_save(64'hA000_0000_0000_0000 + 64'(i));
        chk(bank_cnt == 3, "R2 count after saves", bank_cnt, 3);
        do_restore();
        @(negedge clk);
        chk(bank_cnt == 2, "R3 count after restore", bank_cnt, 2);
        do_restore();
        @(negedge clk);

        // R11 save and restore in the same cycle: save acted on
        model.push_back(64'hBEEF_0000_0000_0011);
        pulse(1'b1, 1'b1, 64'hBEEF_0000_0000_0011, 4'h0);
        @(negedge clk);
        chk(bank_cnt == 2, "R11 count after simultaneous requests", bank_cnt, 2);
        do_restore();
        @(negedge clk);
        do_restore();
        @(negedge clk);
        chk(bank_cnt == 0, "R3 drained", bank_cnt, 0);
        chk(dq.size() == 0, "R3 restores seen", dq.size(), 0);

        // R6 underflow with slow acknowledge, R12 hold
        ack_delay = 2;
        sr_cur = 32'h4000_00C3;
        expect_trap(vec_base + UNF_OFF, 32'h0000_8000, restore_pc, 32'h4000_00C3);
        pulse(1'b0, 1'b1, '0, 4'h0);
        chk(busy == 1'b1, "R10 busy after underflow start", busy, 1);
        wait_idle();
        chk(xq.size() == 0 && rq.size() == 0, "R6 underflow sequence complete",
            xq.size() + rq.size(), 0);
        chk(bank_cnt == 0, "R6 count unchanged", bank_cnt, 0);
        ack_delay = 0;

        // R5 full with trap disabled: absorbed
        for (int i = 0; i < NB; i++) do_save(64'hC000_0000_0000_0000 + 64'(i));
        chk(bank_cnt == CW'(NB), "R2 full count", bank_cnt, NB);
        do_save(64'hDEAD);
        @(negedge clk);
        chk(bank_cnt == CW'(NB) && !busy, "R5 absorbed save", {busy, bank_cnt}, NB);

        // R4 overflow with mask update, R10 requests ignored while busy
        ovf_trap_en = 1'b1;
        sr_cur = 32'h4000_0031;
        expect_trap(vec_base + OVF_OFF, 32'h0000_9000, next_pc, 32'h4000_00A1);
        pulse(1'b1, 1'b0, 64'hDEAD, 4'hA);
        chk(busy == 1'b1, "R10 busy after overflow start", busy, 1);
        pulse(1'b0, 1'b1, '0, 4'h0);
        pulse(1'b1, 1'b0, 64'h5555, 4'h3);
        wait_idle();
        chk(bank_cnt == CW'(NB), "R10 count kept during trap", bank_cnt, NB);
        chk(xq.size() == 0 && rq.size() == 0, "R4 overflow sequence complete",
            xq.size() + rq.size(), 0);

        // R3 banks intact after overflow
        do_restore();
        @(negedge clk);
        chk(dq.size() == 0, "R3 top bank after overflow", dq.size(), 0);
        chk(bank_cnt == CW'(NB - 1), "R3 count after overflow", bank_cnt, NB - 1);

        finish_run();
    end
endmodule